// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one low-speed USB packet onto the D+ and D- lines. A single start strobe launches either a data packet, whose bytes come from a caller-owned buffer through a combinational read port, or a short handshake made of the sync byte and one caller-supplied PID byte. The block puts the sync byte in front of the payload. It encodes every bit as NRZI and inserts stuff bits. It then ends the packet with an exact end-of-packet sequence and hands the lines back in the released state.

The caller fills the buffer and selects data or handshake mode. It then pulses `start` and waits for `busy` to fall. CRC bytes are part of the buffer, because the block does not compute them. The block also holds the device address. A value presented on `new_addr` becomes the active `cur_addr` when a data packet is released. A handshake never changes it.

Top module: `usbls_tx`

## Requirements
- R1: While reset is held and after it, `busy`, `line_oe`, `line_dp`, `line_dm` are 0 and `cur_addr` is 0.
- R2: On the edge that accepts a start, the lines go to J (`line_dp`=0, `line_dm`=1) with `line_oe` still 0. One clock later `line_oe` rises with J held. The first sync bit appears LEAD_CLKS clocks after that (default 4).
- R3: The first byte on the wire is the sync value 0x80, followed by buffer bytes read at `rd_addr` 0, 1, 2 and so on. Each byte is sent least significant bit first. `byte_count` is the total including sync.
- R4: NRZI coding: a 0 bit flips the line between J and K (K is `line_dp`=1, `line_dm`=0), and a 1 bit keeps the previous level.
- R5: After six consecutive 1 bits, one extra 0 bit is sent. The count of ones continues across byte boundaries, starts from zero at sync, and still applies after the final data bit before end of packet.
- R6: Every bit, stuffed or not, lasts CLKS_PER_BIT clocks (default 10).
- R7: End of packet is SE0 (both lines 0, drivers on) for two bit times, then J for one bit time. After that `line_oe`, `line_dp` and `line_dm` all go to 0.
- R8: With `handshake`=1 the packet is sync followed by `hs_pid` only, and `byte_count` is not used.
- R9: `cur_addr` takes the value of `new_addr` on the release edge of a data packet. It stays unchanged after a handshake and at all other times.
- R10: A start is ignored while `busy` is 1, and it is also ignored in data mode when `byte_count` is outside 2..MAX_BYTES (default 12).
- R11: `busy` is 1 from the accepting edge until the release edge. While `busy` is 0 the lines and `line_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLKS_PER_BIT cycles per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, sampled when idle |
| handshake | input | 1 | 1 selects sync plus `hs_pid` only |
| hs_pid | input | 8 | PID byte for handshake packets |
| byte_count | input | 4 | Total bytes including sync for data packets |
| rd_addr | output | 4 | Index of the next buffer byte to read |
| rd_data | input | 8 | Buffer byte at `rd_addr`, combinational |
| new_addr | input | 7 | Pending device address |
| cur_addr | output | 7 | Active device address |
| line_dp | output | 1 | D+ drive level |
| line_dm | output | 1 | D- drive level |
| line_oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |

## Verification
The release edge of a packet is also the edge where a new start could be sampled, and where the pending address is committed. The bench holds `start` high across that release edge and checks that no second packet begins. In the same test it checks that `cur_addr` moves exactly on that edge for a data packet and stays put for a handshake. A second overlap, a start request during the bit stream with a different mode and count, is judged by decoding the full packet and comparing it with the original buffer.

// File: rtl/usbls_tx_pkg.sv
// Shared types and constants for the low-speed USB transmitter.
package usbls_tx_pkg;

    // Transmit sequencer phases, in order of a packet.
    typedef enum logic [2:0] {
        TX_IDLE = 3'd0,
        TX_PREP = 3'd1,
        TX_LEAD = 3'd2,
        TX_DATA = 3'd3,
        TX_SE0  = 3'd4,
        TX_JEND = 3'd5
    } tx_state_e;

    // Synchronisation byte, sent least significant bit first.
    localparam logic [7:0] SYNC_BYTE = 8'h80;

    // Number of consecutive ones after which a zero is forced.
    localparam int STUFF_RUN = 6;

endpackage

// File: rtl/usbls_tx_timer.sv
// Down-counter for bit slots and bus phases.
// Assumes: load has priority; expired is high while the count is zero.
module usbls_tx_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Count down to zero and reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/usbls_tx_bitsrc.sv
// Bit source: yields the sync byte, then buffer bytes or the handshake PID,
// one bit per advance, LSB first. It raises done after the last bit.
// Assumes: rd_data is valid combinationally for the current rd_addr.
module usbls_tx_bitsrc
    import usbls_tx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             hs_in,
    input  logic [7:0]       pid_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             advance,
    input  logic [7:0]       rd_data,
    output logic [CNT_W-1:0] rd_addr,
    output logic             bit_out,
    output logic             done
);

    logic [7:0]       sh_q;
    logic [2:0]       pos_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] idx_q;
    logic [7:0]       pid_q;
    logic             hs_q;
    logic             done_q;

    // Shift out the current byte and fetch the next one on the eighth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            pos_q  <= '0;
            left_q <= '0;
            idx_q  <= '0;
            pid_q  <= '0;
            hs_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (load) begin
            sh_q   <= SYNC_BYTE;
            pos_q  <= '0;
            left_q <= hs_in ? CNT_W'(1) : (count_in - CNT_W'(1));
            idx_q  <= '0;
            pid_q  <= pid_in;
            hs_q   <= hs_in;
            done_q <= 1'b0;
        end else if (advance) begin
            if (pos_q == 3'd7) begin
                pos_q <= '0;
                if (left_q == '0) begin
                    done_q <= 1'b1;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                    sh_q   <= hs_q ? pid_q : rd_data;
                    if (!hs_q) begin
                        idx_q <= idx_q + CNT_W'(1);
                    end
                end
            end else begin
                sh_q  <= {1'b0, sh_q[7:1]};
                pos_q <= pos_q + 3'd1;
            end
        end
    end

    assign rd_addr = idx_q;
    assign bit_out = sh_q[0];
    assign done    = done_q;

endmodule

// File: rtl/usbls_tx_nrzi.sv
// NRZI line encoder with bit stuffing. level=1 means J, level=0 means K.
// Assumes: stuff and advance are never high together.
module usbls_tx_nrzi
    import usbls_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stuff,
    input  logic advance,
    input  logic bit_in,
    output logic level,
    output logic stuff_due
);

    logic [2:0] ones_q;
    logic       level_q;

    // Track the line level and the run of ones across the whole packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q  <= '0;
            level_q <= 1'b1;
        end else if (load) begin
            ones_q  <= '0;
            level_q <= 1'b1;
        end else if (stuff) begin
            ones_q  <= '0;
            level_q <= ~level_q;
        end else if (advance) begin
            if (bit_in) begin
                ones_q <= ones_q + 3'd1;
            end else begin
                ones_q  <= '0;
                level_q <= ~level_q;
            end
        end
    end

    assign level     = level_q;
    assign stuff_due = (ones_q == 3'(STUFF_RUN));

endmodule

// File: rtl/usbls_tx_addr.sv
// Active device address register; takes the pending value on commit.
module usbls_tx_addr #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] new_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] addr_q;

    // Hold the active address and replace it only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (commit) begin
            addr_q <= new_addr;
        end
    end

    assign cur_addr = addr_q;

endmodule

// File: rtl/usbls_tx.sv
// Low-speed USB packet transmitter top. It sequences prepare, lead-in,
// the bit stream, SE0, the final J and release, and commits the device
// address after data packets.
// Assumes: rd_data follows rd_addr combinationally; CRC is in the buffer.
module usbls_tx
    import usbls_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 10,
    parameter int LEAD_CLKS    = 4,
    parameter int MAX_BYTES    = 12,
    parameter int ADDR_W       = 7,
    localparam int CNT_W       = $clog2(MAX_BYTES + 1),
    localparam int TMR_W       = $clog2(2 * CLKS_PER_BIT + LEAD_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              handshake,
    input  logic [7:0]        hs_pid,
    input  logic [CNT_W-1:0]  byte_count,
    output logic [CNT_W-1:0]  rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] new_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              line_dp,
    output logic              line_dm,
    output logic              line_oe,
    output logic              busy
);

    localparam logic [TMR_W-1:0] LD_LEAD = TMR_W'(LEAD_CLKS - 1);
    localparam logic [TMR_W-1:0] LD_BIT  = TMR_W'(CLKS_PER_BIT - 1);
    localparam logic [TMR_W-1:0] LD_SE0  = TMR_W'(2 * CLKS_PER_BIT - 1);

    tx_state_e        state_q;
    logic             pkt_hs_q;
    logic             tmr_zero, tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             stuff_due, src_done, src_bit, enc_level;
    logic             count_ok, accept, slot, do_stuff, do_adv, data_end, commit;

    assign count_ok = (byte_count >= CNT_W'(2)) && (byte_count <= CNT_W'(MAX_BYTES));
    assign accept   = (state_q == TX_IDLE) && start && (handshake || count_ok);
    assign slot     = tmr_zero && ((state_q == TX_LEAD) || (state_q == TX_DATA));
    assign do_stuff = slot && stuff_due;
    assign do_adv   = slot && !stuff_due && !src_done;
    assign data_end = slot && !stuff_due && src_done;
    assign commit   = (state_q == TX_JEND) && tmr_zero && !pkt_hs_q;

    // Pick the reload value of the phase timer for the coming phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            TX_PREP: begin
                tmr_load = 1'b1;
                tmr_val  = LD_LEAD;
            end
            TX_LEAD, TX_DATA: begin
                if (slot) begin
                    tmr_load = 1'b1;
                    tmr_val  = data_end ? LD_SE0 : LD_BIT;
                end
            end
            TX_SE0: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_BIT;
                end
            end
            default: ;
        endcase
    end

    // Step the packet phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            pkt_hs_q <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (accept) begin
                    state_q  <= TX_PREP;
                    pkt_hs_q <= handshake;
                end
                TX_PREP: state_q <= TX_LEAD;
                TX_LEAD: if (slot) state_q <= TX_DATA;
                TX_DATA: if (data_end) state_q <= TX_SE0;
                TX_SE0:  if (tmr_zero) state_q <= TX_JEND;
                TX_JEND: if (tmr_zero) state_q <= TX_IDLE;
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    usbls_tx_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    usbls_tx_bitsrc #(.CNT_W(CNT_W)) u_bitsrc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .hs_in    (handshake),
        .pid_in   (hs_pid),
        .count_in (byte_count),
        .advance  (do_adv),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .bit_out  (src_bit),
        .done     (src_done)
    );

    usbls_tx_nrzi u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .stuff     (do_stuff),
        .advance   (do_adv),
        .bit_in    (src_bit),
        .level     (enc_level),
        .stuff_due (stuff_due)
    );

    usbls_tx_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .new_addr (new_addr),
        .cur_addr (cur_addr)
    );

    // Map the phase and the encoder level onto the line pins.
    always_comb begin
        unique case (state_q)
            TX_PREP:          begin line_dp = 1'b0;       line_dm = 1'b1;      line_oe = 1'b0; end
            TX_LEAD, TX_DATA: begin line_dp = ~enc_level; line_dm = enc_level; line_oe = 1'b1; end
            TX_SE0:           begin line_dp = 1'b0;       line_dm = 1'b0;      line_oe = 1'b1; end
            TX_JEND:          begin line_dp = 1'b0;       line_dm = 1'b1;      line_oe = 1'b1; end
            default:          begin line_dp = 1'b0;       line_dm = 1'b0;      line_oe = 1'b0; end
        endcase
    end

    assign busy = (state_q != TX_IDLE);

endmodule

// File: rtl/usbls_tx_chk.sv
// Property checker for usbls_tx, attached by bind below.
module usbls_tx_chk #(
    parameter int CLKS_PER_BIT = 10,
    parameter int LEAD_CLKS    = 4,
    parameter int ADDR_W       = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              line_oe,
    input logic              line_dp,
    input logic              line_dm,
    input logic [ADDR_W-1:0] cur_addr
);

    localparam int MAX_RUN = 7 * CLKS_PER_BIT + LEAD_CLKS;

    logic [15:0] run_q;
    logic [1:0]  prev_q;

    // Count clocks for which a driven J or K level stays unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= {line_dp, line_dm};
            if (line_oe && (line_dp ^ line_dm) && ({line_dp, line_dm} == prev_q)) begin
                run_q <= run_q + 16'd1;
            end else begin
                run_q <= '0;
            end
        end
    end

    assert_j_before_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> (!line_dp && line_dm && $past(!line_dp && line_dm)));

    assert_start_via_prep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_oe);

    assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < 16'(MAX_RUN));

    assert_eop_then_j_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && $past(line_oe) && $past(!line_dp && !line_dm) && (line_dp || line_dm))
            |-> (!line_dp && line_dm));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!line_oe && !line_dp && !line_dm));

    assert_addr_only_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_addr) |-> $fell(busy));

    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_oe && !line_dp && !line_dm));

endmodule

bind usbls_tx usbls_tx_chk #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .LEAD_CLKS    (LEAD_CLKS),
    .ADDR_W       (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .line_oe  (line_oe),
    .line_dp  (line_dp),
    .line_dm  (line_dm),
    .cur_addr (cur_addr)
);

// File: tb/usbls_tx_bench.sv
// Self-checking bench: decodes NRZI and stuffing from the pins and
// compares the recovered bytes with the expected packet.
module usbls_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 10;
    localparam int LEAD       = 4;
    localparam int MAXB       = 12;
    localparam int AW         = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          handshake = 1'b0;
    logic [7:0]    hs_pid = 8'h00;
    logic [3:0]    byte_count = 4'd0;
    logic [3:0]    rd_addr;
    logic [7:0]    rd_data;
    logic [AW-1:0] new_addr = '0;
    logic [AW-1:0] cur_addr;
    logic          line_dp, line_dm, line_oe, busy;

    logic [7:0]    pkt_buf [0:MAXB-2];
    logic [7:0]    exp_bytes [0:15];
    logic [7:0]    dec_bytes [0:15];
    logic [AW-1:0] addr_model = '0;
    int            n_checks = 0;
    int            n_fail = 0;

    assign rd_data = (rd_addr < 4'(MAXB - 1)) ? pkt_buf[rd_addr] : 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usbls_tx u_usbls_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .handshake  (handshake),
        .hs_pid     (hs_pid),
        .byte_count (byte_count),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .new_addr   (new_addr),
        .cur_addr   (cur_addr),
        .line_dp    (line_dp),
        .line_dm    (line_dm),
        .line_oe    (line_oe),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected number of bit slots, stuffed bits included.
    function automatic int calc_slots(input int nbytes);
        int ones = 0;
        int slots = 0;
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 0; b < 8; b++) begin
                slots++;
                if (exp_bytes[i][b]) ones++; else ones = 0;
                if (ones == 6) begin
                    slots++;
                    ones = 0;
                end
            end
        end
        return slots;
    endfunction

    task automatic send_packet(input bit hs, input logic [7:0] pid, input int cnt,
                               input logic [AW-1:0] na, input bit inject, input bit late_start);
        int nbytes, slots, nbits, ones, stuff_err, exp_sl;
        logic prev_lv, lv, bitv;
        logic [AW-1:0] prev_addr;
        nbytes = hs ? 2 : cnt;
        exp_bytes[0] = 8'h80;
        for (int i = 1; i < nbytes; i++) exp_bytes[i] = hs ? pid : pkt_buf[i-1];
        for (int i = 0; i < 16; i++) dec_bytes[i] = 8'h00;
        prev_addr = addr_model;
        @(negedge clk);
        start = 1'b1; handshake = hs; hs_pid = pid; new_addr = na;
        byte_count = hs ? 4'd0 : 4'(cnt);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after accept", busy, 1);
        check({line_oe, line_dp, line_dm} == 3'b001, "R2", "J before enable",
              {line_oe, line_dp, line_dm}, 3'b001);
        @(negedge clk);
        check({line_oe, line_dp, line_dm} == 3'b101, "R2", "enable with J",
              {line_oe, line_dp, line_dm}, 3'b101);
        repeat (LEAD - 1) @(negedge clk);
        check(line_dm == 1'b1, "R2", "J through lead-in", line_dm, 1);
        @(negedge clk);
        check({line_dp, line_dm} == 2'b10, "R4", "first sync bit is K",
              {line_dp, line_dm}, 2'b10);
        repeat (CPB / 2) @(negedge clk);
        prev_lv = 1'b1; slots = 0; nbits = 0; ones = 0; stuff_err = 0;
        while (!(line_dp == 1'b0 && line_dm == 1'b0) && slots < 300) begin
            lv = line_dm;
            bitv = (lv == prev_lv);
            prev_lv = lv;
            slots++;
            if (ones == 6) begin
                if (bitv) stuff_err++;
                ones = 0;
            end else begin
                if (bitv) ones++; else ones = 0;
                if (nbits < 128) dec_bytes[nbits / 8][nbits % 8] = bitv;
                nbits++;
            end
            if (inject && slots == 20) begin
                start = 1'b1; handshake = ~hs; byte_count = (cnt == 2) ? 4'd3 : 4'd2;
                @(negedge clk);
                start = 1'b0; handshake = hs; byte_count = hs ? 4'd0 : 4'(cnt);
                repeat (CPB - 1) @(negedge clk);
            end else begin
                repeat (CPB) @(negedge clk);
            end
        end
        exp_sl = calc_slots(nbytes);
        check(stuff_err == 0, "R5", "stuffed bit missing", stuff_err, 0);
        check(slots == exp_sl, "R5", "bit slots incl. stuffing", slots, exp_sl);
        check(nbits == nbytes * 8, "R3", "decoded bit count", nbits, nbytes * 8);
        for (int i = 0; i < nbytes; i++)
            check(dec_bytes[i] == exp_bytes[i], hs ? "R8" : "R3", "decoded byte",
                  dec_bytes[i], exp_bytes[i]);
        check(cur_addr == prev_addr, "R9", "address held during EOP", cur_addr, prev_addr);
        repeat (CPB + CPB / 2 - 1) @(negedge clk);
        check({line_oe, line_dp, line_dm} == 3'b100, "R7", "SE0 for two bits",
              {line_oe, line_dp, line_dm}, 3'b100);
        @(negedge clk);
        check({line_oe, line_dp, line_dm} == 3'b101, "R7", "J after SE0",
              {line_oe, line_dp, line_dm}, 3'b101);
        repeat (CPB - 1) @(negedge clk);
        check({busy, line_oe, line_dp, line_dm} == 4'b1101, "R6", "J lasts one bit",
              {busy, line_oe, line_dp, line_dm}, 4'b1101);
        if (late_start) begin
            start = 1'b1; handshake = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        check({busy, line_oe, line_dp, line_dm} == 4'b0000, "R7", "released after J",
              {busy, line_oe, line_dp, line_dm}, 4'b0000);
        if (!hs) addr_model = na;
        check(cur_addr == addr_model, "R9", "address after release", cur_addr, addr_model);
        if (late_start) begin
            @(negedge clk);
            check({busy, line_oe} == 2'b00, "R10", "start on release edge ignored",
                  {busy, line_oe}, 2'b00);
        end
    endtask

    task automatic bad_start(input int cnt);
        @(negedge clk);
        start = 1'b1; handshake = 1'b0; byte_count = 4'(cnt);
        @(negedge clk);
        start = 1'b0;
        check({busy, line_oe, line_dm} == 3'b000, "R10", "out-of-range count ignored",
              {busy, line_oe, line_dm}, 3'b000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int cnt;
        logic [7:0] tmp;
        seed = $urandom(32'd7391);
        for (int i = 0; i < MAXB - 1; i++) pkt_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        check({busy, line_oe, line_dp, line_dm} == 4'b0000, "R1", "outputs in reset",
              {busy, line_oe, line_dp, line_dm}, 4'b0000);
        check(cur_addr == '0, "R1", "address in reset", cur_addr, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, line_oe, line_dp, line_dm} == 4'b0000, "R1", "idle after reset",
              {busy, line_oe, line_dp, line_dm}, 4'b0000);

        bad_start(1);
        bad_start(13);

        // All ones: stuffing runs across every byte boundary.
        for (int i = 0; i < MAXB - 1; i++) pkt_buf[i] = 8'hFF;
        send_packet(1'b0, 8'h00, MAXB, 7'h15, 1'b1, 1'b0);
        // Six ones at the very end force a stuff bit before EOP.
        pkt_buf[0] = 8'hFC;
        send_packet(1'b0, 8'h00, 2, 7'h2A, 1'b0, 1'b0);
        // Handshakes leave the address alone; start held on release edge.
        send_packet(1'b1, 8'hD2, 0, 7'h7F, 1'b0, 1'b1);
        send_packet(1'b1, 8'h5A, 0, 7'h01, 1'b1, 1'b0);
        // Data packet with a start on its release edge.
        pkt_buf[0] = 8'h3F; pkt_buf[1] = 8'h00; pkt_buf[2] = 8'h7E;
        send_packet(1'b0, 8'h00, 4, 7'h33, 1'b0, 1'b1);

        for (int p = 0; p < 10; p++) begin
            cnt = 2 + int'($urandom_range(MAXB - 2, 0));
            for (int i = 0; i < MAXB - 1; i++) begin
                tmp = 8'($urandom());
                pkt_buf[i] = ($urandom_range(3, 0) == 0) ? 8'hFF : tmp;
            end
            tmp = 8'($urandom());
            send_packet($urandom_range(4, 0) == 0, tmp, cnt, 7'(tmp ^ 8'h5C),
                        $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule